// File: doc/BRIEF.md
# Stream Width Repacking Gearbox

This block gathers one sample from each of a set of parallel input streams on every cycle that the input is marked valid, and treats those samples as one wide input word. It packs the resulting bit stream, without gaps or padding, into much wider memory write words. The output width is not a whole multiple of the input width, so the bits of an input word that do not fit are kept in a carry buffer and become the low bits of the next output word.

Each time a full output word is assembled, the block raises a write strobe for one clock. On that clock it presents the packed word and a write address. The address steps by one after every write and wraps at the end of its range. A separate output reports how many bits are waiting in the carry buffer. Input is never stalled, so a downstream memory controller must take a write on every strobe.

Top module: `stream_gearbox`

## Requirements
- R1: The input word is the concatenation of the streams. Stream 0 takes bits [13:0], and stream s takes bits [14s+13 : 14s] of the 168-bit word.
- R2: Packing is contiguous with the least significant bit first. Output word n (counting from 1) equals bits [576n-1 : 576(n-1)] of all accepted input words, joined in arrival order with the earliest input at bit 0.
- R3: `wr_en` is high for exactly one clock for each completed 576-bit word. It is never high on two consecutive clocks.
- R4: `held_bits` equals the total number of accepted input bits minus 576 times the number of writes issued. It is always below 576.
- R5: `wr_addr` is 0 on the first write after reset. It advances by one after each write and wraps from 15 to 0.
- R6: A cycle with `in_valid` low produces no write and leaves `held_bits` and `wr_addr` unchanged.
- R7: A synchronous active-high `rst` clears the carry buffer and `held_bits`, drops `wr_en`, sets `wr_addr` to 0, and discards any partial word.
- R8: The write that completes on an accepted input word appears on the clock edge that accepts that word. `held_bits` updates on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Samples on `in_samples` are accepted this cycle |
| in_samples | input | 168 | All stream samples, stream 0 in the lowest bits |
| wr_en | output | 1 | One-cycle write strobe per completed word |
| wr_addr | output | 4 | Write address for the current strobe |
| wr_data | output | 576 | Packed word, valid while `wr_en` is high |
| held_bits | output | 10 | Number of bits waiting in the carry buffer |

## Verification
The bench feeds a ramp in which every sample carries its own index. Any swapped stream, a reversed bit order or a carry seam placed at the wrong offset therefore shows up as a wrong bit in some output word. Gaps in `in_valid` are mixed into the stream. A design that accepted samples while invalid, or that counted a gap as data, would then drift out of step with the bit count and with the data. The run lasts long enough for the address to wrap more than once, which exposes an address that stops at 15 or skips on a four-input word. A reset in the middle of a partial word checks that leftover bits are thrown away rather than leaking into the first word after reset.

// File: rtl/stream_gearbox.sv
module stream_gearbox #(
  parameter int NUM_STREAMS = 12,
  parameter int SAMPLE_W    = 14,
  parameter int WORD_W      = 576,
  parameter int ADDR_W      = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic [NUM_STREAMS*SAMPLE_W-1:0]      in_samples,
  output logic                                 wr_en,
  output logic [ADDR_W-1:0]                    wr_addr,
  output logic [WORD_W-1:0]                    wr_data,
  output logic [$clog2(WORD_W+NUM_STREAMS*SAMPLE_W)-1:0] held_bits
);
  localparam int IN_W  = NUM_STREAMS * SAMPLE_W;
  localparam int BUF_W = WORD_W + IN_W - 1;
  localparam int CNT_W = $clog2(BUF_W + 1);

  // stream s already sits at bits [s*SAMPLE_W +: SAMPLE_W] of in_samples
  logic [BUF_W-1:0] carry_q, merged;
  logic [CNT_W-1:0] fill_q, fill_sum;
  logic             full;

  assign merged    = carry_q | (BUF_W'(in_samples) << fill_q);
  assign fill_sum  = fill_q + CNT_W'(IN_W);
  assign full      = fill_sum >= CNT_W'(WORD_W);
  assign held_bits = fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= '0;
      fill_q  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= in_valid && full;
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      if (in_valid) begin
        if (full) begin
          wr_data <= merged[WORD_W-1:0];
          carry_q <= merged >> WORD_W;
          fill_q  <= fill_sum - CNT_W'(WORD_W);
        end else begin
          carry_q <= merged;
          fill_q  <= fill_sum;
        end
      end
    end
  end
endmodule

// File: rtl/stream_gearbox_chk.sv
module stream_gearbox_chk #(
  parameter int WORD_W = 576,
  parameter int IN_W   = 168,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  held_bits
);
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_held_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(held_bits) < WORD_W);

  p_held_account_r4_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> int'(held_bits) + (wr_en ? WORD_W : 0) == int'($past(held_bits)) + IN_W);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wr_addr == $past(wr_addr) + 1'b1);

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wr_en && $stable(held_bits));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_addr));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> !wr_en && held_bits == '0 && wr_addr == '0);
endmodule

bind stream_gearbox stream_gearbox_chk #(
  .WORD_W(WORD_W),
  .IN_W(NUM_STREAMS*SAMPLE_W),
  .ADDR_W(ADDR_W),
  .CNT_W($clog2(WORD_W+NUM_STREAMS*SAMPLE_W))
) u_chk (
  .clk(clk),
  .rst(rst),
  .in_valid(in_valid),
  .wr_en(wr_en),
  .wr_addr(wr_addr),
  .held_bits(held_bits)
);

// File: tb/test_stream_gearbox.sv
module test_stream_gearbox;
  localparam int NS = 12;
  localparam int SW = 14;
  localparam int IW = NS * SW;
  localparam int OW = 576;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [IW-1:0]  in_samples = '0;
  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic [OW-1:0]  wr_data;
  logic [9:0]     held_bits;

  stream_gearbox i_stream_gearbox (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .held_bits(held_bits)
  );

  bit          ref_q[$];
  int          exp_addr = 0;
  bit          exp_wr = 0;
  logic [OW-1:0] exp_data = '0;
  int          sample_k = 0;
  int          checks = 0;
  int          errors = 0;
  int          writes_seen = 0;
  bit          done = 0;

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_word(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance model, sample at the next negedge
  task automatic step(bit v, bit r);
    rst = r;
    in_valid = v;
    if (v && !r) begin
      for (int s = 0; s < NS; s++) begin
        in_samples[s*SW +: SW] = SW'(sample_k);
        sample_k++;
      end
    end else begin
      in_samples = {IW{1'b1}};
    end
    if (r) begin
      ref_q.delete();
      exp_addr = 0;
      exp_wr = 0;
    end else begin
      if (exp_wr) exp_addr = (exp_addr + 1) % (1 << AW);
      exp_wr = 0;
      if (v) begin
        for (int b = 0; b < IW; b++) ref_q.push_back(in_samples[b]);
        if (ref_q.size() >= OW) begin
          for (int b = 0; b < OW; b++) exp_data[b] = ref_q.pop_front();
          exp_wr = 1;
        end
      end
    end
    @(negedge clk);
    chk_int("R3 R6 R8 wr_en", int'(wr_en), int'(exp_wr));
    chk_int("R4 R8 held_bits", int'(held_bits), ref_q.size());
    if (exp_wr) begin
      writes_seen++;
      chk_int("R5 wr_addr", int'(wr_addr), exp_addr);
      chk_word("R1 R2 wr_data", wr_data, exp_data);
    end
  endtask

  initial begin
    @(negedge clk);
    step(0, 1);
    step(0, 1);
    // R7: reset state
    chk_int("R7 reset wr_en", int'(wr_en), 0);
    chk_int("R7 reset held_bits", int'(held_bits), 0);
    chk_int("R7 reset wr_addr", int'(wr_addr), 0);
    // continuous ramp, long enough to wrap the address (R5)
    for (int i = 0; i < 120; i++) step(1, 0);
    // R6: gaps in the valid pattern
    for (int i = 0; i < 150; i++) step((i % 5) != 2 && (i % 11) != 7, 0);
    // R7: reset in the middle of a partial word
    step(1, 0);
    step(1, 0);
    step(0, 1);
    chk_int("R7 mid reset held_bits", int'(held_bits), 0);
    chk_int("R7 mid reset wr_addr", int'(wr_addr), 0);
    for (int i = 0; i < 80; i++) step((i % 3) != 0, 0);
    chk_int("R5 wrap exercised", int'(writes_seen > 2 * (1 << AW)), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule